// File: doc/BRIEF.md
# Revision Protection Guard

This block holds a read-lock bit and a write-lock bit for each stored design revision of a configuration store. For every incoming command it decides whether the command may proceed. It then raises a one-cycle grant or a one-cycle deny and updates the lock bits. Reads and verifies are refused on a read-locked revision. Program and erase are refused on a write-locked revision. A write lock can be removed only by an unlock that is followed directly by an erase of the same revision. A read lock is removed only by an erase.

Program and erase run on the storage array, which lies outside this block. A granted program or erase marks the guard busy. An `op_done` strobe ends the operation, and when the operation is an erase it clears both lock bits of the erased revision. A separate view shows the lock state of the active revision. The active revision comes either from external select pins or from internally held select bits, and an enable input chooses between the two sources.

Top module: `rev_guard`

## Requirements
- R1: After reset every read-lock and write-lock bit is 0, `busy` is 0, and `grant`, `deny` and `act_rev` are 0.
- R2: A read command (code 1) is granted when the target revision's read-lock bit is 0 and denied when it is 1.
- R3: A set read-lock bit refuses neither program (code 2) nor erase (code 3) of that revision.
- R4: When the target revision's write-lock bit is 1, program and erase are denied, unless the erase directly follows an unlock of that revision as R5 allows. Set-read-lock is code 4 and set-write-lock is code 5.
- R5: An unlock (code 6) of a revision followed directly by an erase of that same revision is granted, even when that revision is write-locked.
- R6: A pending unlock is cancelled by any non-NOP command other than the erase it enables. An erase of a different revision also cancels it. After cancellation, an erase of the write-locked revision is denied.
- R7: Lock bits are cleared only at the `op_done` that ends an erase. That `op_done` clears both bits of the erased revision. A program's `op_done` leaves the bits unchanged.
- R8: `grant` and `deny` appear one cycle after the request, last one cycle and never appear together. A denied request leaves every lock bit unchanged.
- R9: With `sel_ext_en` at 1 the active revision is `ext_sel`; otherwise it is `int_sel`. `act_rev`, `act_rd_prot` and `act_wr_prot` show that revision one cycle later, including any lock change made on that same edge.
- R10: A granted program or erase sets `busy` on the next cycle. While `busy` is 1 every command is denied. `op_done` clears `busy`.
- R11: Lock bits are per revision. Setting a lock on one revision leaves the other revisions unchanged. `rd_prot[i]` and `wr_prot[i]` belong to revision i.
- R12: Code 0 (NOP) with `req_valid` produces neither grant nor deny. The unassigned code 7 is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present this cycle |
| req_cmd | input | 3 | Command code |
| req_rev | input | REV_W | Target revision of the command |
| op_done | input | 1 | Array operation finished |
| sel_ext_en | input | 1 | 1: use external select pins for the active revision |
| ext_sel | input | REV_W | External revision select pins |
| int_sel | input | REV_W | Internally held revision select bits |
| grant | output | 1 | Command accepted (one-cycle pulse) |
| deny | output | 1 | Command refused (one-cycle pulse) |
| busy | output | 1 | Program or erase in progress |
| rd_prot | output | NUM_REV | Read-lock bit per revision |
| wr_prot | output | NUM_REV | Write-lock bit per revision |
| act_rev | output | REV_W | Active revision |
| act_rd_prot | output | 1 | Read lock of the active revision |
| act_wr_prot | output | 1 | Write lock of the active revision |

## Verification
A request sampled at a rising edge produces `grant` or `deny`, any lock-bit change and any change to `busy` after that same edge, so every result is due one cycle after the request. An `op_done` clears `busy` and the erased revision's bits one cycle after it is applied. The active-revision view follows a select change by one cycle. The bench drives every input at the falling edge and holds it for exactly one cycle. It reads results at the next falling edge, which is the first point where the registered outputs can have changed. Repeat reads of `deny` at the following falling edge confirm that it lasts only one cycle.

// File: rtl/rev_guard_pkg.sv
package rev_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_READ   = 3'd1,
    CMD_PROG   = 3'd2,
    CMD_ERASE  = 3'd3,
    CMD_SET_RP = 3'd4,
    CMD_SET_WP = 3'd5,
    CMD_UNLOCK = 3'd6
  } cmd_e;

  typedef struct packed {
    logic grant;
    logic deny;
    logic set_rp;
    logic set_wp;
    logic start_op;
    logic is_erase;
    logic arm_unlock;
    logic drop_unlock;
  } verdict_t;

endpackage

// File: rtl/rg_decide.sv
module rg_decide
  import rev_guard_pkg::*;
#(
  parameter int REV_W = 2
) (
  input  logic             valid,
  input  logic [2:0]       cmd,
  input  logic [REV_W-1:0] rev,
  input  logic             rp_bit,
  input  logic             wp_bit,
  input  logic             busy,
  input  logic             unl_pend,
  input  logic [REV_W-1:0] unl_rev,
  output verdict_t         v
);

  logic  active;
  logic  ok;
  logic  unl_hit;
  cmd_e  c;

  assign c       = cmd_e'(cmd);
  assign active  = valid && (c != CMD_NOP);
  assign unl_hit = unl_pend && (unl_rev == rev);

  always_comb begin
    v  = '0;
    ok = 1'b0;
    case (c)
      CMD_READ:   ok = !rp_bit;
      CMD_PROG:   ok = !wp_bit;
      CMD_ERASE:  ok = !wp_bit || unl_hit;
      CMD_SET_RP: ok = 1'b1;
      CMD_SET_WP: ok = 1'b1;
      CMD_UNLOCK: ok = 1'b1;
      default:    ok = 1'b0;
    endcase
    ok            = ok && !busy;
    v.grant       = active && ok;
    v.deny        = active && !ok;
    v.set_rp      = v.grant && (c == CMD_SET_RP);
    v.set_wp      = v.grant && (c == CMD_SET_WP);
    v.start_op    = v.grant && ((c == CMD_PROG) || (c == CMD_ERASE));
    v.is_erase    = (c == CMD_ERASE);
    v.arm_unlock  = v.grant && (c == CMD_UNLOCK);
    v.drop_unlock = active;
  end

endmodule

// File: rtl/rg_prot_store.sv
module rg_prot_store #(
  parameter int NUM_REV = 4,
  parameter int REV_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_rp,
  input  logic               set_wp,
  input  logic [REV_W-1:0]   set_rev,
  input  logic               clr_en,
  input  logic [REV_W-1:0]   clr_rev,
  output logic [NUM_REV-1:0] rp_q,
  output logic [NUM_REV-1:0] wp_q,
  output logic [NUM_REV-1:0] rp_d,
  output logic [NUM_REV-1:0] wp_d
);

  for (genvar i = 0; i < NUM_REV; i++) begin : g_rev
    localparam logic [REV_W-1:0] IDX = REV_W'(i);

    always_comb begin
      rp_d[i] = rp_q[i];
      wp_d[i] = wp_q[i];
      if (clr_en && (clr_rev == IDX)) begin
        rp_d[i] = 1'b0;
        wp_d[i] = 1'b0;
      end
      if (set_rp && (set_rev == IDX)) rp_d[i] = 1'b1;
      if (set_wp && (set_rev == IDX)) wp_d[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rp_q[i] <= 1'b0;
        wp_q[i] <= 1'b0;
      end else begin
        rp_q[i] <= rp_d[i];
        wp_q[i] <= wp_d[i];
      end
    end
  end

endmodule

// File: rtl/rg_rev_select.sv
module rg_rev_select #(
  parameter int NUM_REV = 4,
  parameter int REV_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_en,
  input  logic [REV_W-1:0]   ext_sel,
  input  logic [REV_W-1:0]   int_sel,
  input  logic [NUM_REV-1:0] rp_next,
  input  logic [NUM_REV-1:0] wp_next,
  output logic [REV_W-1:0]   act_rev,
  output logic               act_rp,
  output logic               act_wp
);

  logic [REV_W-1:0] pick;

  assign pick = ext_en ? ext_sel : int_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_rev <= '0;
      act_rp  <= 1'b0;
      act_wp  <= 1'b0;
    end else begin
      act_rev <= pick;
      act_rp  <= rp_next[pick];
      act_wp  <= wp_next[pick];
    end
  end

endmodule

// File: rtl/rev_guard.sv
module rev_guard
  import rev_guard_pkg::*;
#(
  parameter int NUM_REV = 4,
  parameter int REV_W   = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_cmd,
  input  logic [REV_W-1:0]   req_rev,
  input  logic               op_done,
  input  logic               sel_ext_en,
  input  logic [REV_W-1:0]   ext_sel,
  input  logic [REV_W-1:0]   int_sel,
  output logic               grant,
  output logic               deny,
  output logic               busy,
  output logic [NUM_REV-1:0] rd_prot,
  output logic [NUM_REV-1:0] wr_prot,
  output logic [REV_W-1:0]   act_rev,
  output logic               act_rd_prot,
  output logic               act_wr_prot
);

  verdict_t           v;
  logic               busy_q, op_erase_q, unl_pend_q;
  logic [REV_W-1:0]   op_rev_q, unl_rev_q;
  logic               grant_q, deny_q;
  logic               clr_en;
  logic [NUM_REV-1:0] rp_q, wp_q, rp_d, wp_d;

  rg_decide #(.REV_W(REV_W)) u_decide (
    .valid    (req_valid),
    .cmd      (req_cmd),
    .rev      (req_rev),
    .rp_bit   (rp_q[req_rev]),
    .wp_bit   (wp_q[req_rev]),
    .busy     (busy_q),
    .unl_pend (unl_pend_q),
    .unl_rev  (unl_rev_q),
    .v        (v)
  );

  assign clr_en = busy_q && op_done && op_erase_q;

  rg_prot_store #(.NUM_REV(NUM_REV), .REV_W(REV_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .set_rp  (v.set_rp),
    .set_wp  (v.set_wp),
    .set_rev (req_rev),
    .clr_en  (clr_en),
    .clr_rev (op_rev_q),
    .rp_q    (rp_q),
    .wp_q    (wp_q),
    .rp_d    (rp_d),
    .wp_d    (wp_d)
  );

  rg_rev_select #(.NUM_REV(NUM_REV), .REV_W(REV_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .ext_en  (sel_ext_en),
    .ext_sel (ext_sel),
    .int_sel (int_sel),
    .rp_next (rp_d),
    .wp_next (wp_d),
    .act_rev (act_rev),
    .act_rp  (act_rd_prot),
    .act_wp  (act_wr_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      op_erase_q <= 1'b0;
      op_rev_q   <= '0;
      unl_pend_q <= 1'b0;
      unl_rev_q  <= '0;
      grant_q    <= 1'b0;
      deny_q     <= 1'b0;
    end else begin
      grant_q <= v.grant;
      deny_q  <= v.deny;
      if (v.start_op) begin
        busy_q     <= 1'b1;
        op_erase_q <= v.is_erase;
        op_rev_q   <= req_rev;
      end else if (op_done && busy_q) begin
        busy_q <= 1'b0;
      end
      if (v.arm_unlock) begin
        unl_pend_q <= 1'b1;
        unl_rev_q  <= req_rev;
      end else if (v.drop_unlock) begin
        unl_pend_q <= 1'b0;
      end
    end
  end

  assign grant   = grant_q;
  assign deny    = deny_q;
  assign busy    = busy_q;
  assign rd_prot = rp_q;
  assign wr_prot = wp_q;

endmodule

// File: rtl/rev_guard_chk.sv
module rev_guard_chk
  import rev_guard_pkg::*;
#(
  parameter int NUM_REV = 4,
  parameter int REV_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [2:0]         req_cmd,
  input logic [REV_W-1:0]   req_rev,
  input logic               op_done,
  input logic               sel_ext_en,
  input logic [REV_W-1:0]   ext_sel,
  input logic [REV_W-1:0]   int_sel,
  input logic               grant,
  input logic               deny,
  input logic               busy,
  input logic [NUM_REV-1:0] rd_prot,
  input logic [NUM_REV-1:0] wr_prot,
  input logic [REV_W-1:0]   act_rev
);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_prot == '0 && wr_prot == '0 && !busy && !grant && !deny));

  p_read_lock_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cmd == CMD_READ && rd_prot[req_rev]) |=> deny);

  p_prog_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cmd == CMD_PROG && wr_prot[req_rev]) |=> deny);

  p_one_of_r8: assert property (@(posedge clk) disable iff (rst)
    !(grant && deny));

  p_deny_cause_r8: assert property (@(posedge clk) disable iff (rst)
    deny |-> $past(req_valid));

  p_deny_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (deny && !$past(op_done)) |-> (rd_prot == $past(rd_prot) && wr_prot == $past(wr_prot)));

  p_ext_sel_r9: assert property (@(posedge clk) disable iff (rst)
    sel_ext_en |=> (act_rev == $past(ext_sel)));

  p_int_sel_r9: assert property (@(posedge clk) disable iff (rst)
    !sel_ext_en |=> (act_rev == $past(int_sel)));

  p_busy_deny_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid && req_cmd != CMD_NOP) |=> deny);

  for (genvar i = 0; i < NUM_REV; i++) begin : g_clr
    p_clear_on_done_r7: assert property (@(posedge clk) disable iff (rst)
      ($fell(rd_prot[i]) || $fell(wr_prot[i])) |-> $past(op_done && busy));
  end

endmodule

bind rev_guard rev_guard_chk #(.NUM_REV(NUM_REV), .REV_W(REV_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_rev(req_rev),
  .op_done(op_done), .sel_ext_en(sel_ext_en), .ext_sel(ext_sel), .int_sel(int_sel),
  .grant(grant), .deny(deny), .busy(busy), .rd_prot(rd_prot), .wr_prot(wr_prot),
  .act_rev(act_rev)
);

// File: tb/sim_rev_guard.sv
module sim_rev_guard;

  localparam int NUM_REV = 4;
  localparam int REV_W   = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic [2:0]         req_cmd = '0;
  logic [REV_W-1:0]   req_rev = '0;
  logic               op_done = 1'b0;
  logic               sel_ext_en = 1'b0;
  logic [REV_W-1:0]   ext_sel = '0;
  logic [REV_W-1:0]   int_sel = '0;
  logic               grant, deny, busy, act_rd_prot, act_wr_prot;
  logic [NUM_REV-1:0] rd_prot, wr_prot;
  logic [REV_W-1:0]   act_rev;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rev_guard #(.NUM_REV(NUM_REV)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_rev(req_rev),
    .op_done(op_done), .sel_ext_en(sel_ext_en), .ext_sel(ext_sel), .int_sel(int_sel),
    .grant(grant), .deny(deny), .busy(busy), .rd_prot(rd_prot), .wr_prot(wr_prot),
    .act_rev(act_rev), .act_rd_prot(act_rd_prot), .act_wr_prot(act_wr_prot)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic req(logic [2:0] cmd, logic [REV_W-1:0] rev);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_rev = rev;
    @(negedge clk);
    req_valid = 1'b0; req_cmd = '0; req_rev = '0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_prot", rd_prot, 0);
    chk("R1 wr_prot", wr_prot, 0);
    chk("R1 busy", busy, 0);
    chk("R1 grant/deny", {grant, deny}, 0);
    chk("R1 act_rev", act_rev, 0);
  endtask

  task automatic t_read_lock();
    req(3'd1, 2'd1); chk("R2 read open rev1 grant", {grant, deny}, 2'b10);
    req(3'd4, 2'd1); chk("R11 set rp rev1 only", rd_prot, 4'b0010);
    req(3'd1, 2'd1); chk("R2 read locked rev1 deny", {grant, deny}, 2'b01);
    @(negedge clk);  chk("R8 deny one cycle", deny, 0);
    req(3'd1, 2'd2); chk("R11 read rev2 still open", {grant, deny}, 2'b10);
  endtask

  task automatic t_rp_write_busy();
    req(3'd2, 2'd1); chk("R3 program rp rev1 grant", {grant, deny}, 2'b10);
    chk("R10 busy after program", busy, 1);
    req(3'd1, 2'd0); chk("R10 read while busy deny", {grant, deny}, 2'b01);
    finish_op();
    chk("R10 busy cleared by done", busy, 0);
    chk("R7 program keeps rp", rd_prot, 4'b0010);
    req(3'd3, 2'd1); chk("R3 erase rp rev1 grant", {grant, deny}, 2'b10);
    chk("R7 rp held until done", rd_prot, 4'b0010);
    finish_op();
    chk("R7 erase done clears rp", rd_prot, 0);
  endtask

  task automatic t_write_lock();
    req(3'd5, 2'd2); chk("R11 set wp rev2 only", wr_prot, 4'b0100);
    req(3'd2, 2'd2); chk("R4 program wp rev2 deny", {grant, deny}, 2'b01);
    chk("R8 deny keeps wp", wr_prot, 4'b0100);
    chk("R4 denied program not busy", busy, 0);
    req(3'd3, 2'd2); chk("R4 plain erase wp deny", {grant, deny}, 2'b01);
  endtask

  task automatic t_unlock_cancel();
    req(3'd6, 2'd2); chk("R6 unlock grant", {grant, deny}, 2'b10);
    req(3'd1, 2'd0); chk("R6 intervening read grant", {grant, deny}, 2'b10);
    req(3'd3, 2'd2); chk("R6 erase after cancel deny", {grant, deny}, 2'b01);
    req(3'd6, 2'd3);
    req(3'd3, 2'd2); chk("R6 unlock other rev deny", {grant, deny}, 2'b01);
    chk("R6 wp still set", wr_prot, 4'b0100);
  endtask

  task automatic t_unlock_erase();
    req(3'd4, 2'd2); chk("R11 rp rev2", rd_prot, 4'b0100);
    req(3'd6, 2'd2);
    req(3'd3, 2'd2); chk("R5 unlock then erase grant", {grant, deny}, 2'b10);
    chk("R5 wp held until done", wr_prot, 4'b0100);
    finish_op();
    chk("R5 wp cleared", wr_prot, 0);
    chk("R7 rp cleared with erase", rd_prot, 0);
  endtask

  task automatic t_codes();
    req(3'd7, 2'd0); chk("R12 code 7 deny", {grant, deny}, 2'b01);
    req(3'd0, 2'd0); chk("R12 NOP silent", {grant, deny}, 2'b00);
  endtask

  task automatic t_select();
    @(negedge clk);
    sel_ext_en = 1'b1; ext_sel = 2'd3; int_sel = 2'd1;
    req(3'd5, 2'd3);
    chk("R9 ext select", act_rev, 3);
    chk("R9 active wp same edge", act_wr_prot, 1);
    chk("R9 active rp", act_rd_prot, 0);
    chk("R11 wp rev3 only", wr_prot, 4'b1000);
    @(negedge clk);
    sel_ext_en = 1'b0;
    @(negedge clk);
    chk("R9 int select", act_rev, 1);
    chk("R9 int rev wp clear", act_wr_prot, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_lock();
        t_rp_write_busy();
        t_write_lock();
        t_unlock_cancel();
        t_unlock_erase();
        t_codes();
        t_select();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule